// File: doc/BRIEF.md
# Conditional Correlated Multiple Sampling Controller

This block sequences the conversions of a single-slope column converter and accumulates the codes it returns, so that one pixel read produces one noise-reduced digital value. For every pixel it requests a series of reset-level conversions: the first over the full ramp range and the rest over the narrow, finer ramp. It then requests one full-range conversion of the signal level. That code is compared with a threshold to decide whether the pixel is bright or dark. A bright pixel uses that single conversion as its signal. A dark pixel discards it and has its signal converted M more times on the narrow ramp.

Each set of samples is summed and divided by M with a shift, because M is a power of two. The averaged reset is subtracted from the averaged signal. All arithmetic is done in narrow-ramp LSB units. A full-ramp code is multiplied by 2^GAIN_SH, which is the fixed ratio of the two ramp slopes, so reset and signal are always compared on the same scale.

The converter side is a request/response pair. `conv_start` pulses once, with `ramp_small` choosing the ramp. The converter may then answer after any delay by raising `adc_valid` with its code. A code is taken only on a cycle where `adc_valid` and `adc_ready` are both high, and the converter may hold `adc_valid` for as long as it needs. The result side is a valid/ready output. `res_valid` rises with the difference and the bright flag, and all three hold steady until the first cycle in which `res_ready` is high. A consumer that keeps `res_ready` high sees a one-cycle valid pulse. A new pixel read starts only from idle, after the result has been taken.

Top module: `cms_ctrl`

## Requirements
- R1: After reset, `conv_start`, `adc_ready` and `res_valid` are low, and they stay low until `start` is seen.
- R2: A `start` seen while idle begins a read whose first M conversion requests are reset samples. The first uses the full ramp (`ramp_small`=0) and the others use the narrow ramp (`ramp_small`=1). Each request is a one-cycle `conv_start` pulse. The next request is issued only after the previous code has been accepted.
- R3: `adc_ready` is high only while a requested conversion is outstanding. An `adc_valid` seen while `adc_ready` is low has no effect on the result or on the request sequence.
- R4: After the reset samples, exactly one full-ramp signal request is issued. If its code is at or above `thresh`, the pixel is bright: no further requests are made, `res_bright`=1, and the signal average is that code times 2^GAIN_SH.
- R5: If the decision code is below `thresh`, the pixel is dark and `res_bright`=0. M more narrow-ramp requests follow, and the signal average is floor(sum of the M codes / M).
- R6: The reset average is floor((first code times 2^GAIN_SH + sum of the M-1 narrow codes) / M).
- R7: `res_data` is the signal average minus the reset average, as a two's-complement value of CODE_W+GAIN_SH+1 bits, so it may be negative.
- R8: `res_valid` and its `res_data` and `res_bright` stay stable until `res_ready` is high. The read then ends and `res_valid` falls on the next cycle. A `start` given while a read or a held result is in progress is ignored.
- R9: The decision compares the code with `thresh` inclusively: a code equal to `thresh` is bright and a code of `thresh`-1 is dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pixel read (taken only when idle) |
| thresh | input | CODE_W | Bright/dark threshold in full-ramp codes |
| conv_start | output | 1 | One-cycle conversion request |
| ramp_small | output | 1 | Ramp of the current request: 1 narrow, 0 full |
| adc_valid | input | 1 | Converter code is valid |
| adc_ready | output | 1 | Block is waiting for a code |
| adc_code | input | CODE_W | Converter code |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | CODE_W+GAIN_SH+1 | Signal average minus reset average, narrow-ramp LSB units |
| res_bright | output | 1 | 1 when the pixel was judged bright |

## Verification
The bench drives reads where the decision code equals the threshold and where it is one below it. An off-by-one comparator would flip the bright flag and change both the number of conversions and the result. It chooses reset and signal codes whose sums do not divide by M, and a signal lower than the reset. A design that rounds instead of truncating, skips the full-ramp scaling of the first reset code, or loses the sign would then report a wrong difference. It also stalls the result with `res_ready` low while pulsing `start`, and drives `adc_valid` while no conversion is pending. A design that drops or changes a held result, restarts early, or takes a stray code would show extra requests or a corrupted value.

// File: rtl/cms_pkg.sv
package cms_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_REQ,
    ST_RST_WAIT,
    ST_DEC_REQ,
    ST_DEC_WAIT,
    ST_SIG_REQ,
    ST_SIG_WAIT,
    ST_DONE
  } seq_st_e;

endpackage

// File: rtl/cms_scale.sv
// Brings a converter code to narrow-ramp LSB units.
module cms_scale #(
  parameter int CODE_W  = 10,
  parameter int GAIN_SH = 3,
  localparam int SCL_W  = CODE_W + GAIN_SH
) (
  input  logic [CODE_W-1:0] code,
  input  logic              full_ramp,
  output logic [SCL_W-1:0]  scaled
);

  always_comb begin
    if (full_ramp) scaled = {code, {GAIN_SH{1'b0}}};
    else           scaled = {{GAIN_SH{1'b0}}, code};
  end

endmodule

// File: rtl/cms_accum.sv
// Sum of M scaled samples; a load places one sample pre-multiplied by M.
module cms_accum #(
  parameter int SCL_W  = 13,
  parameter int LOG2_M = 2,
  localparam int ACC_W = SCL_W + LOG2_M
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add,
  input  logic             load,
  input  logic [SCL_W-1:0] din,
  output logic [SCL_W-1:0] avg
);

  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (clr)  acc_q <= '0;
    else if (load) acc_q <= {din, {LOG2_M{1'b0}}};
    else if (add)  acc_q <= acc_q + {{LOG2_M{1'b0}}, din};
  end

  assign avg = acc_q[ACC_W-1:LOG2_M];

endmodule

// File: rtl/cms_seq.sv
// Conversion request sequencer and result handshake.
module cms_seq
  import cms_pkg::*;
#(
  parameter int LOG2_M = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic adc_valid,
  input  logic is_bright,
  input  logic res_ready,
  output logic conv_start,
  output logic ramp_small,
  output logic adc_ready,
  output logic res_valid,
  output logic res_bright,
  output logic acc_clr,
  output logic rst_add,
  output logic sig_add,
  output logic sig_load
);

  seq_st_e           st_q, st_d;
  logic [LOG2_M-1:0] cnt_q, cnt_d;
  logic              bright_q, bright_d;
  logic              take;
  logic              last;

  assign take = adc_valid && adc_ready;
  assign last = &cnt_q;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    bright_d = bright_q;
    acc_clr  = 1'b0;
    rst_add  = 1'b0;
    sig_add  = 1'b0;
    sig_load = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d    = ST_RST_REQ;
        cnt_d   = '0;
        acc_clr = 1'b1;
      end
      ST_RST_REQ: st_d = ST_RST_WAIT;
      ST_RST_WAIT: if (take) begin
        rst_add = 1'b1;
        if (last) begin
          cnt_d = '0;
          st_d  = ST_DEC_REQ;
        end else begin
          cnt_d = cnt_q + 1'b1;
          st_d  = ST_RST_REQ;
        end
      end
      ST_DEC_REQ: st_d = ST_DEC_WAIT;
      ST_DEC_WAIT: if (take) begin
        bright_d = is_bright;
        if (is_bright) begin
          sig_load = 1'b1;
          st_d     = ST_DONE;
        end else begin
          st_d = ST_SIG_REQ;
        end
      end
      ST_SIG_REQ: st_d = ST_SIG_WAIT;
      ST_SIG_WAIT: if (take) begin
        sig_add = 1'b1;
        if (last) begin
          cnt_d = '0;
          st_d  = ST_DONE;
        end else begin
          cnt_d = cnt_q + 1'b1;
          st_d  = ST_SIG_REQ;
        end
      end
      ST_DONE: if (res_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      bright_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      bright_q <= bright_d;
    end
  end

  always_comb begin
    conv_start = (st_q == ST_RST_REQ) || (st_q == ST_DEC_REQ) || (st_q == ST_SIG_REQ);
    adc_ready  = (st_q == ST_RST_WAIT) || (st_q == ST_DEC_WAIT) || (st_q == ST_SIG_WAIT);
    res_valid  = (st_q == ST_DONE);
    unique case (st_q)
      ST_RST_REQ, ST_RST_WAIT: ramp_small = (cnt_q != '0);
      ST_SIG_REQ, ST_SIG_WAIT: ramp_small = 1'b1;
      default:                 ramp_small = 1'b0;
    endcase
  end

  assign res_bright = bright_q;

endmodule

// File: rtl/cms_ctrl.sv
// Conditional correlated multiple sampling controller (top).
module cms_ctrl #(
  parameter int CODE_W  = 10,
  parameter int LOG2_M  = 2,
  parameter int GAIN_SH = 3,
  localparam int SCL_W  = CODE_W + GAIN_SH,
  localparam int RES_W  = SCL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] thresh,
  output logic              conv_start,
  output logic              ramp_small,
  input  logic              adc_valid,
  output logic              adc_ready,
  input  logic [CODE_W-1:0] adc_code,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [RES_W-1:0]  res_data,
  output logic              res_bright
);

  logic             is_bright;
  logic             acc_clr, rst_add, sig_add, sig_load;
  logic [SCL_W-1:0] code_scl;
  logic [SCL_W-1:0] rst_avg, sig_avg;

  assign is_bright = (adc_code >= thresh);

  cms_seq #(.LOG2_M(LOG2_M)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .adc_valid  (adc_valid),
    .is_bright  (is_bright),
    .res_ready  (res_ready),
    .conv_start (conv_start),
    .ramp_small (ramp_small),
    .adc_ready  (adc_ready),
    .res_valid  (res_valid),
    .res_bright (res_bright),
    .acc_clr    (acc_clr),
    .rst_add    (rst_add),
    .sig_add    (sig_add),
    .sig_load   (sig_load)
  );

  cms_scale #(.CODE_W(CODE_W), .GAIN_SH(GAIN_SH)) u_scale (
    .code      (adc_code),
    .full_ramp (!ramp_small),
    .scaled    (code_scl)
  );

  cms_accum #(.SCL_W(SCL_W), .LOG2_M(LOG2_M)) u_rst_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (acc_clr),
    .add   (rst_add),
    .load  (1'b0),
    .din   (code_scl),
    .avg   (rst_avg)
  );

  cms_accum #(.SCL_W(SCL_W), .LOG2_M(LOG2_M)) u_sig_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (acc_clr),
    .add   (sig_add),
    .load  (sig_load),
    .din   (code_scl),
    .avg   (sig_avg)
  );

  assign res_data = {1'b0, sig_avg} - {1'b0, rst_avg};

endmodule

// File: rtl/cms_ctrl_chk.sv
module cms_ctrl_chk #(
  parameter int RES_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_start,
  input logic             ramp_small,
  input logic             adc_valid,
  input logic             adc_ready,
  input logic             res_valid,
  input logic             res_ready,
  input logic [RES_W-1:0] res_data,
  input logic             res_bright
);

  // R2
  conv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R2
  conv_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> adc_ready && $stable(ramp_small));

  // R3
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_ready |-> !conv_start && !res_valid);

  // R3
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_ready && !adc_valid |=> adc_ready);

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_bright));

  // R8
  res_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> !res_valid && !conv_start && !adc_ready);

endmodule

bind cms_ctrl cms_ctrl_chk #(.RES_W(CODE_W + GAIN_SH + 1)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_start (conv_start),
  .ramp_small (ramp_small),
  .adc_valid  (adc_valid),
  .adc_ready  (adc_ready),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_data   (res_data),
  .res_bright (res_bright)
);

// File: tb/cms_ctrl_test.sv
`timescale 1ns/1ps
module cms_ctrl_test;

  localparam int CW = 10;
  localparam int LM = 2;
  localparam int M  = 1 << LM;
  localparam int GS = 3;
  localparam int RW = CW + GS + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] thresh = 10'd512;
  logic          conv_start, ramp_small, adc_ready, res_valid, res_bright;
  logic          adc_valid = 1'b0;
  logic [CW-1:0] adc_code = '0;
  logic          res_ready = 1'b1;
  logic [RW-1:0] res_data;

  int n_chk = 0;
  int n_err = 0;
  int codes [0:15];
  int ramps [0:15];
  int nconv;
  int got_res;
  int got_bright;

  always #2.5 clk = ~clk;

  cms_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start(start), .thresh(thresh),
    .conv_start(conv_start), .ramp_small(ramp_small),
    .adc_valid(adc_valid), .adc_ready(adc_ready), .adc_code(adc_code),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_bright(res_bright)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Start a read and answer every request from codes[], after dly cycles.
  task automatic drive_pixel(input int dly);
    nconv = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      if (res_valid) break;
      if (conv_start) begin
        if (nconv < 16) ramps[nconv] = int'(ramp_small);
        repeat (dly) @(negedge clk);
        adc_code  = CW'(codes[(nconv < 16) ? nconv : 15]);
        adc_valid = 1'b1;
        for (int w = 0; w < 50 && !adc_ready; w++) @(negedge clk);
        @(negedge clk);
        adc_valid = 1'b0;
        nconv++;
      end else begin
        @(negedge clk);
      end
    end
    got_res    = int'($signed(res_data));
    got_bright = int'(res_bright);
  endtask

  // Full read with all expectations computed from the requirements.
  task automatic check_pixel(input string name, input int thr, input int dly);
    int rst_sum, sig_avg, rst_avg, exp_n, bright, exp_mask, got_mask;
    thresh = CW'(thr);
    drive_pixel(dly);
    rst_sum = codes[0] << GS;
    for (int i = 1; i < M; i++) rst_sum += codes[i];
    rst_avg = rst_sum >> LM;
    bright  = (codes[M] >= thr) ? 1 : 0;
    if (bright == 1) begin
      sig_avg = codes[M] << GS;
      exp_n   = M + 1;
    end else begin
      sig_avg = 0;
      for (int i = 0; i < M; i++) sig_avg += codes[M + 1 + i];
      sig_avg = sig_avg >> LM;
      exp_n   = 2 * M + 1;
    end
    exp_mask = 0;
    got_mask = 0;
    for (int i = 0; i < exp_n; i++) begin
      if ((i > 0 && i < M) || i > M) exp_mask |= (1 << i);
      if (i < nconv && i < 16) got_mask |= (ramps[i] << i);
    end
    $display("-- %s", name);
    chk(bright == 1 ? "R4 request count (bright)" : "R5 request count (dark)", nconv, exp_n);
    chk("R2 ramp selection per request", got_mask, exp_mask);
    chk("R9 bright flag", got_bright, bright);
    chk("R7/R6 result difference", got_res, sig_avg - rst_avg);
    @(negedge clk);
  endtask

  task automatic set_codes(input int r0, input int r1, input int r2, input int r3,
                           input int d, input int s0, input int s1, input int s2, input int s3);
    codes[0] = r0; codes[1] = r1; codes[2] = r2; codes[3] = r3;
    codes[4] = d;
    codes[5] = s0; codes[6] = s1; codes[7] = s2; codes[8] = s3;
    for (int i = 9; i < 16; i++) codes[i] = 0;
  endtask

  task automatic t_reset_state();
    // R1
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 conv_start idle", int'(conv_start), 0);
      chk("R1 adc_ready idle", int'(adc_ready), 0);
      chk("R1 res_valid idle", int'(res_valid), 0);
    end
  endtask

  task automatic t_dark();
    // R5 R6: dark pixel, sums chosen to leave remainders
    set_codes(12, 101, 98, 103, 40, 421, 419, 418, 425);
    check_pixel("R5 dark pixel", 512, 0);
    set_codes(7, 55, 60, 61, 3, 300, 301, 302, 306);
    check_pixel("R6 dark pixel with slow converter", 512, 3);
  endtask

  task automatic t_bright();
    // R4
    set_codes(15, 120, 118, 121, 800, 0, 0, 0, 0);
    check_pixel("R4 bright pixel", 512, 1);
    set_codes(1023, 1023, 1023, 1023, 1023, 0, 0, 0, 0);
    check_pixel("R4 bright pixel at full scale", 512, 0);
  endtask

  task automatic t_threshold();
    // R9
    set_codes(10, 80, 80, 80, 300, 600, 600, 600, 600);
    check_pixel("R9 decision equal to threshold", 300, 0);
    set_codes(10, 80, 80, 80, 299, 600, 600, 600, 600);
    check_pixel("R9 decision one below threshold", 300, 0);
  endtask

  task automatic t_negative();
    // R7: signal below reset gives a negative difference
    set_codes(50, 410, 405, 402, 20, 100, 90, 95, 97);
    check_pixel("R7 negative difference", 512, 2);
  endtask

  task automatic t_stray_valid();
    // R3: valid while idle is ignored
    @(negedge clk);
    adc_code  = 10'd999;
    adc_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 adc_ready low while nothing requested", int'(adc_ready), 0);
      chk("R3 no request from stray code", int'(conv_start), 0);
    end
    adc_valid = 1'b0;
    set_codes(20, 160, 161, 162, 30, 250, 251, 252, 253);
    check_pixel("R3 read after stray code", 512, 0);
  endtask

  task automatic t_backpressure();
    int held, held_b;
    // R8
    res_ready = 1'b0;
    set_codes(9, 70, 71, 72, 5, 500, 503, 507, 509);
    check_pixel("R8 result under back-pressure", 512, 0);
    held   = got_res;
    held_b = got_bright;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R8 result still valid", int'(res_valid), 1);
      chk("R8 result data held", int'($signed(res_data)), held);
      chk("R8 bright flag held", int'(res_bright), held_b);
      chk("R8 start ignored while held", int'(conv_start), 0);
      @(negedge clk);
    end
    res_ready = 1'b1;
    @(negedge clk);
    chk("R8 valid released after ready", int'(res_valid), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 no restart from ignored start", int'(conv_start), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_dark();
    t_bright();
    t_threshold();
    t_negative();
    t_stray_valid();
    t_backpressure();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule